// File: doc/BRIEF.md
# Host-Side Configuration Address/Data Port Decoder

This block sits on the host's I/O port path. It turns processor port cycles into configuration space requests through a pair of ports: a 32-bit address latch and a four-byte data window directly above it. Software first loads the address latch with an enable flag, a bus number, a device/function number and a dword register index. Each access to the data window then becomes one request to a simple back end. The request carries those fields, byte enables derived from the access size and the port's low address bits, and lane-positioned write data. The back end answers with an acknowledge, an optional abort flag and lane-positioned read data.

Host data is right-justified in both directions. The block shifts write data onto the lanes the access covers. On reads it shifts the selected lanes back down and clears the bytes outside the access size. The address latch responds only to full dword accesses, so software can detect the mechanism by writing the enable pattern and reading it back. A byte written to the highest port of the address block is a separate mode byte and leaves the latch untouched. Any other access the block does not own goes to a pass-through I/O port with the same request/acknowledge handshake. A request that nobody answers completes after a fixed number of cycles: a read returns all ones and a write is dropped.

The host issues one request at a time as a single-cycle pulse and waits for the acknowledge. A pulse raised while a request is still outstanding is ignored.

Top module: `cfgio_decoder`

## Requirements
- R1: After reset the address latch reads 0, the mode byte output is 0, and io_ack, cfg_req and pt_req are all low.
- R2: A dword (io_size=2) write to port ADDR_PORT (0xCF8) stores bits 31:2 of the value. A later dword read of that port returns them with bits 1:0 as zero, so 0x80000000 reads back exactly and any saved value can be restored.
- R3: A byte (io_size=0) write to ADDR_PORT+3 loads the mode byte output mech_mode and leaves the address latch unchanged. A byte read of that port returns the mode byte.
- R4: Any access to ADDR_PORT..ADDR_PORT+3 that is neither a dword at ADDR_PORT nor a byte at ADDR_PORT+3 is sent to the pass-through port and leaves the address latch unchanged.
- R5: With latch bit 31 set, an aligned access to the data window ADDR_PORT+4..+7 raises cfg_req for exactly one cycle, with cfg_bus = latch bits 23:16, cfg_devfn = bits 15:8, cfg_reg = bits 7:2 and cfg_wr equal to the access direction.
- R6: cfg_be (bit n = byte lane n) is 1<<n for a byte access at window offset n, 4'b0011 for a word at offset 0, 4'b1100 for a word at offset 2, and 4'b1111 for a dword at offset 0.
- R7: cfg_wdata carries the right-justified host value shifted left by 8 times the window offset.
- R8: A config read returns cfg_rdata shifted right by 8 times the window offset, with bytes beyond the access size zero.
- R9: With latch bit 31 clear, data-window accesses go to the pass-through port, raise no cfg_req and leave configuration state unchanged.
- R10: A config read acknowledged with cfg_err returns all ones in the bytes of the access size. A config write acknowledged with cfg_err is completed normally.
- R11: A request unanswered for TIMEOUT cycles completes: a read returns all ones in the access size and a write returns 0, with nothing written.
- R12: A word access at an odd window offset or a dword access at a nonzero window offset goes to the pass-through port. Pass-through reads return pt_rdata masked to the access size (byte 0xFF, word 0xFFFF, dword all).
- R13: Every accepted request gets exactly one io_ack. Address-latch and mode-byte accesses get it in the cycle after the request, and cfg_req and pt_req are never high together. Write completions return io_rdata = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | Single-cycle host port request |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | Host port address |
| io_size | input | 2 | 0 byte, 1 word, 2 dword |
| io_wdata | input | 32 | Right-justified write value |
| io_ack | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Right-justified read value, valid with io_ack |
| cfg_req | output | 1 | One-cycle config request pulse |
| cfg_wr | output | 1 | Config request direction |
| cfg_bus | output | 8 | Target bus number |
| cfg_devfn | output | 8 | Target device/function number |
| cfg_reg | output | 6 | Target dword register index |
| cfg_be | output | 4 | Byte-lane enables |
| cfg_wdata | output | 32 | Lane-positioned write data |
| cfg_ack | input | 1 | Back-end completion |
| cfg_err | input | 1 | Abort flag, valid with cfg_ack |
| cfg_rdata | input | 32 | Lane-positioned read data, valid with cfg_ack |
| pt_req | output | 1 | One-cycle pass-through request pulse |
| pt_wr | output | 1 | Pass-through direction |
| pt_addr | output | IO_AW | Pass-through port address |
| pt_size | output | 2 | Pass-through access size |
| pt_wdata | output | 32 | Pass-through write value |
| pt_ack | input | 1 | Pass-through completion |
| pt_rdata | input | 32 | Right-justified pass-through read value |
| mech_mode | output | 8 | Last written mode byte |

## Verification
The checker watches properties that hold on every cycle. Config requests are single-cycle pulses, and their byte enables always cover one, two or four lanes. Config and pass-through requests never coincide. Address-latch accesses are acknowledged one cycle later. Mode-byte and narrow writes near the latch never change it, and a data-window access with the enable flag clear never produces a config request. Only the bench scenarios can show the data values: the exact readback of the enable pattern and of arbitrary saved values, the lane steering in both directions against a back-end memory model, the masking of abort and timeout reads to the access size, and the absence of any write to that memory when a write is aborted, times out or is routed to pass-through.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;

  // Classification of one host port access.
  typedef enum logic [2:0] {
    K_ADDR_WR,
    K_ADDR_RD,
    K_MODE_WR,
    K_MODE_RD,
    K_CFG,
    K_PASS
  } acc_kind_e;

  // Host access size encoding.
  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  // Sequencer state.
  typedef enum logic [1:0] {
    S_IDLE,
    S_CFG,
    S_PT
  } seq_state_e;

endpackage

// File: rtl/cfgio_classify.sv
module cfgio_classify
  import cfgio_pkg::*;
#(
  parameter int               IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8
) (
  input  logic [IO_AW-1:0] addr,
  input  logic [1:0]       size,
  input  logic             wr,
  input  logic             cfg_en,
  output acc_kind_e        kind
);

  localparam logic [IO_AW-1:0] MODE_PORT = ADDR_PORT + IO_AW'(3);
  localparam logic [IO_AW-1:0] DATA_BASE = ADDR_PORT + IO_AW'(4);

  logic in_window;
  logic aligned;

  assign in_window = (addr[IO_AW-1:2] == DATA_BASE[IO_AW-1:2]);

  always_comb begin
    case (size)
      SZ_BYTE:  aligned = 1'b1;
      SZ_WORD:  aligned = ~addr[0];
      SZ_DWORD: aligned = (addr[1:0] == 2'b00);
      default:  aligned = 1'b0;
    endcase
  end

  always_comb begin
    if ((addr == ADDR_PORT) && (size == SZ_DWORD)) begin
      kind = wr ? K_ADDR_WR : K_ADDR_RD;
    end else if ((addr == MODE_PORT) && (size == SZ_BYTE)) begin
      kind = wr ? K_MODE_WR : K_MODE_RD;
    end else if (in_window && cfg_en && aligned) begin
      kind = K_CFG;
    end else begin
      kind = K_PASS;
    end
  end

endmodule

// File: rtl/cfgio_regs.sv
module cfgio_regs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_we,
  input  logic          mode_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] addr_q,
  output logic [7:0]    mode_q
);

  // Bits 1:0 of the latch are never stored.
  logic [DW-3:0] idx_q, idx_d;
  logic [7:0]    mode_r, mode_d;

  always_comb begin
    idx_d  = idx_q;
    mode_d = mode_r;
    if (addr_we) idx_d  = wdata[DW-1:2];
    if (mode_we) mode_d = wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      mode_r <= '0;
    end else begin
      if (addr_we) idx_q  <= idx_d;
      if (mode_we) mode_r <= mode_d;
    end
  end

  assign addr_q = {idx_q, 2'b00};
  assign mode_q = mode_r;

endmodule

// File: rtl/cfgio_lanes.sv
module cfgio_lanes
  import cfgio_pkg::*;
#(
  parameter int NLANE = 4,
  localparam int DW   = 8 * NLANE,
  localparam int LW   = $clog2(NLANE)
) (
  input  logic [1:0]    req_size,
  input  logic [LW-1:0] req_low,
  input  logic [DW-1:0] req_wdata,
  output logic [NLANE-1:0] req_be,
  output logic [DW-1:0] req_lane_wdata,
  input  logic [1:0]    rsp_size,
  input  logic [LW-1:0] rsp_low,
  input  logic [DW-1:0] rsp_lane_data,
  output logic [DW-1:0] rsp_data,
  output logic [DW-1:0] rsp_ones
);

  logic [LW:0] req_nb, rsp_nb, lo_ext, hi_ext;

  always_comb begin
    case (req_size)
      SZ_BYTE: req_nb = (LW+1)'(1);
      SZ_WORD: req_nb = (LW+1)'(2);
      default: req_nb = (LW+1)'(NLANE);
    endcase
    case (rsp_size)
      SZ_BYTE: rsp_nb = (LW+1)'(1);
      SZ_WORD: rsp_nb = (LW+1)'(2);
      default: rsp_nb = (LW+1)'(NLANE);
    endcase
  end

  assign lo_ext = {1'b0, req_low};
  assign hi_ext = lo_ext + req_nb;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign req_be[g] = ((LW+1)'(g) >= lo_ext) && ((LW+1)'(g) < hi_ext);
    assign rsp_ones[8*g +: 8] = {8{(LW+1)'(g) < rsp_nb}};
  end

  assign req_lane_wdata = req_wdata << {req_low, 3'b000};
  assign rsp_data       = (rsp_lane_data >> {rsp_low, 3'b000}) & rsp_ones;

endmodule

// File: rtl/cfgio_seq.sv
module cfgio_seq
  import cfgio_pkg::*;
#(
  parameter int IO_AW   = 16,
  parameter int TIMEOUT = 64,
  parameter int NLANE   = 4,
  localparam int DW     = 8 * NLANE,
  localparam int LW     = $clog2(NLANE),
  localparam int CW     = $clog2(TIMEOUT) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req,
  input  logic             io_wr,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  input  logic [DW-1:0]    io_wdata,
  input  acc_kind_e        kind,
  input  logic [DW-1:0]    addr_q,
  input  logic [7:0]       mode_q,
  input  logic [NLANE-1:0] req_be,
  input  logic [DW-1:0]    req_lane_wdata,
  output logic             idle,
  output logic [1:0]       held_size,
  output logic [LW-1:0]    held_low,
  input  logic [DW-1:0]    rsp_data,
  input  logic [DW-1:0]    rsp_ones,
  output logic             io_ack,
  output logic [DW-1:0]    io_rdata,
  output logic             cfg_req,
  output logic             cfg_wr,
  output logic [7:0]       cfg_bus,
  output logic [7:0]       cfg_devfn,
  output logic [5:0]       cfg_reg,
  output logic [NLANE-1:0] cfg_be,
  output logic [DW-1:0]    cfg_wdata,
  input  logic             cfg_ack,
  input  logic             cfg_err,
  output logic             pt_req,
  output logic             pt_wr,
  output logic [IO_AW-1:0] pt_addr,
  output logic [1:0]       pt_size,
  output logic [DW-1:0]    pt_wdata,
  input  logic             pt_ack,
  input  logic [DW-1:0]    pt_rdata
);

  seq_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ack_q, ack_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          cfgreq_q, cfgreq_d;
  logic          ptreq_q, ptreq_d;
  logic          load_cfg, load_pt;
  logic          tmo;

  // Held request context.
  logic             wr_q;
  logic [1:0]       size_q;
  logic [LW-1:0]    low_q;
  logic [7:0]       bus_q, devfn_q;
  logic [5:0]       reg_q;
  logic [NLANE-1:0] be_q;
  logic [DW-1:0]    cwdata_q;
  logic [IO_AW-1:0] paddr_q;
  logic [DW-1:0]    pwdata_q;

  assign tmo = (cnt_q == CW'(TIMEOUT - 1));

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    ack_d    = 1'b0;
    rdata_d  = rdata_q;
    cfgreq_d = 1'b0;
    ptreq_d  = 1'b0;
    load_cfg = 1'b0;
    load_pt  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (io_req) begin
          case (kind)
            K_ADDR_WR, K_MODE_WR: begin
              ack_d   = 1'b1;
              rdata_d = '0;
            end
            K_ADDR_RD: begin
              ack_d   = 1'b1;
              rdata_d = addr_q;
            end
            K_MODE_RD: begin
              ack_d   = 1'b1;
              rdata_d = {{(DW-8){1'b0}}, mode_q};
            end
            K_CFG: begin
              cfgreq_d = 1'b1;
              load_cfg = 1'b1;
              st_d     = S_CFG;
              cnt_d    = '0;
            end
            default: begin
              ptreq_d = 1'b1;
              load_pt = 1'b1;
              st_d    = S_PT;
              cnt_d   = '0;
            end
          endcase
        end
      end
      S_CFG: begin
        if (cfg_ack) begin
          ack_d   = 1'b1;
          rdata_d = wr_q ? '0 : (cfg_err ? rsp_ones : rsp_data);
          st_d    = S_IDLE;
        end else if (tmo) begin
          ack_d   = 1'b1;
          rdata_d = wr_q ? '0 : rsp_ones;
          st_d    = S_IDLE;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      S_PT: begin
        if (pt_ack) begin
          ack_d   = 1'b1;
          rdata_d = wr_q ? '0 : (pt_rdata & rsp_ones);
          st_d    = S_IDLE;
        end else if (tmo) begin
          ack_d   = 1'b1;
          rdata_d = wr_q ? '0 : rsp_ones;
          st_d    = S_IDLE;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      ack_q    <= 1'b0;
      rdata_q  <= '0;
      cfgreq_q <= 1'b0;
      ptreq_q  <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      ack_q    <= ack_d;
      rdata_q  <= rdata_d;
      cfgreq_q <= cfgreq_d;
      ptreq_q  <= ptreq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      size_q <= '0;
      low_q  <= '0;
    end else if (load_cfg || load_pt) begin
      wr_q   <= io_wr;
      size_q <= io_size;
      low_q  <= io_addr[LW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q    <= '0;
      devfn_q  <= '0;
      reg_q    <= '0;
      be_q     <= '0;
      cwdata_q <= '0;
    end else if (load_cfg) begin
      bus_q    <= addr_q[23:16];
      devfn_q  <= addr_q[15:8];
      reg_q    <= addr_q[7:2];
      be_q     <= req_be;
      cwdata_q <= req_lane_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q  <= '0;
      pwdata_q <= '0;
    end else if (load_pt) begin
      paddr_q  <= io_addr;
      pwdata_q <= io_wdata;
    end
  end

  assign idle      = (st_q == S_IDLE);
  assign held_size = size_q;
  assign held_low  = low_q;
  assign io_ack    = ack_q;
  assign io_rdata  = rdata_q;
  assign cfg_req   = cfgreq_q;
  assign cfg_wr    = wr_q;
  assign cfg_bus   = bus_q;
  assign cfg_devfn = devfn_q;
  assign cfg_reg   = reg_q;
  assign cfg_be    = be_q;
  assign cfg_wdata = cwdata_q;
  assign pt_req    = ptreq_q;
  assign pt_wr     = wr_q;
  assign pt_addr   = paddr_q;
  assign pt_size   = size_q;
  assign pt_wdata  = pwdata_q;

endmodule

// File: rtl/cfgio_decoder.sv
module cfgio_decoder
  import cfgio_pkg::*;
#(
  parameter int               IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter int               TIMEOUT   = 64,
  parameter int               NLANE     = 4,
  localparam int              DW        = 8 * NLANE,
  localparam int              LW        = $clog2(NLANE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req,
  input  logic             io_wr,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  input  logic [DW-1:0]    io_wdata,
  output logic             io_ack,
  output logic [DW-1:0]    io_rdata,
  output logic             cfg_req,
  output logic             cfg_wr,
  output logic [7:0]       cfg_bus,
  output logic [7:0]       cfg_devfn,
  output logic [5:0]       cfg_reg,
  output logic [NLANE-1:0] cfg_be,
  output logic [DW-1:0]    cfg_wdata,
  input  logic             cfg_ack,
  input  logic             cfg_err,
  input  logic [DW-1:0]    cfg_rdata,
  output logic             pt_req,
  output logic             pt_wr,
  output logic [IO_AW-1:0] pt_addr,
  output logic [1:0]       pt_size,
  output logic [DW-1:0]    pt_wdata,
  input  logic             pt_ack,
  input  logic [DW-1:0]    pt_rdata,
  output logic [7:0]       mech_mode
);

  acc_kind_e        kind;
  logic             seq_idle;
  logic [DW-1:0]    cfg_addr_q;
  logic [7:0]       mode_q;
  logic [NLANE-1:0] req_be;
  logic [DW-1:0]    req_lane_wdata;
  logic [1:0]       held_size;
  logic [LW-1:0]    held_low;
  logic [DW-1:0]    rsp_data, rsp_ones;
  logic             accept;

  assign accept = io_req && seq_idle;

  cfgio_classify #(.IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT)) u_classify (
    .addr   (io_addr),
    .size   (io_size),
    .wr     (io_wr),
    .cfg_en (cfg_addr_q[DW-1]),
    .kind   (kind)
  );

  cfgio_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_we (accept && (kind == K_ADDR_WR)),
    .mode_we (accept && (kind == K_MODE_WR)),
    .wdata   (io_wdata),
    .addr_q  (cfg_addr_q),
    .mode_q  (mode_q)
  );

  cfgio_lanes #(.NLANE(NLANE)) u_lanes (
    .req_size       (io_size),
    .req_low        (io_addr[LW-1:0]),
    .req_wdata      (io_wdata),
    .req_be         (req_be),
    .req_lane_wdata (req_lane_wdata),
    .rsp_size       (held_size),
    .rsp_low        (held_low),
    .rsp_lane_data  (cfg_rdata),
    .rsp_data       (rsp_data),
    .rsp_ones       (rsp_ones)
  );

  cfgio_seq #(.IO_AW(IO_AW), .TIMEOUT(TIMEOUT), .NLANE(NLANE)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .io_req         (io_req),
    .io_wr          (io_wr),
    .io_addr        (io_addr),
    .io_size        (io_size),
    .io_wdata       (io_wdata),
    .kind           (kind),
    .addr_q         (cfg_addr_q),
    .mode_q         (mode_q),
    .req_be         (req_be),
    .req_lane_wdata (req_lane_wdata),
    .idle           (seq_idle),
    .held_size      (held_size),
    .held_low       (held_low),
    .rsp_data       (rsp_data),
    .rsp_ones       (rsp_ones),
    .io_ack         (io_ack),
    .io_rdata       (io_rdata),
    .cfg_req        (cfg_req),
    .cfg_wr         (cfg_wr),
    .cfg_bus        (cfg_bus),
    .cfg_devfn      (cfg_devfn),
    .cfg_reg        (cfg_reg),
    .cfg_be         (cfg_be),
    .cfg_wdata      (cfg_wdata),
    .cfg_ack        (cfg_ack),
    .cfg_err        (cfg_err),
    .pt_req         (pt_req),
    .pt_wr          (pt_wr),
    .pt_addr        (pt_addr),
    .pt_size        (pt_size),
    .pt_wdata       (pt_wdata),
    .pt_ack         (pt_ack),
    .pt_rdata       (pt_rdata)
  );

  assign mech_mode = mode_q;

endmodule

// File: rtl/cfgio_decoder_chk.sv
module cfgio_decoder_chk #(
  parameter int               IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter int               NLANE     = 4,
  localparam int              DW        = 8 * NLANE
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_req,
  input logic             io_wr,
  input logic [IO_AW-1:0] io_addr,
  input logic [1:0]       io_size,
  input logic             io_ack,
  input logic             cfg_req,
  input logic [NLANE-1:0] cfg_be,
  input logic             pt_req,
  input logic [DW-1:0]    cfg_addr_q,
  input logic             seq_idle
);

  localparam logic [IO_AW-1:0] MODE_PORT = ADDR_PORT + IO_AW'(3);
  localparam logic [IO_AW-1:0] DATA_BASE = ADDR_PORT + IO_AW'(4);

  logic taken, hits_latch_blk, hits_window;
  assign taken          = io_req && seq_idle;
  assign hits_latch_blk = (io_addr[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2]);
  assign hits_window    = (io_addr[IO_AW-1:2] == DATA_BASE[IO_AW-1:2]);

  // R5: a config request lasts exactly one cycle
  p_cfg_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |=> !cfg_req);

  // R6: byte enables cover one, two or four lanes
  p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> ($countones(cfg_be) == 1 || $countones(cfg_be) == 2 ||
                 $countones(cfg_be) == 4));

  // R9: no config request while the enable flag is clear
  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && hits_window && !cfg_addr_q[DW-1]) |=> !cfg_req);

  // R3: the mode byte write keeps the latch
  p_mode_keeps_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && io_wr && io_addr == MODE_PORT && io_size == 2'd0) |=> $stable(cfg_addr_q));

  // R4: narrow writes to the latch block keep the latch
  p_narrow_keeps_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && io_wr && hits_latch_blk && io_size != 2'd2) |=> $stable(cfg_addr_q));

  // R13: latch accesses complete in the next cycle
  p_latch_ack_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && io_addr == ADDR_PORT && io_size == 2'd2) |=> io_ack);

  // R13: never both back ends at once
  p_one_target_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && pt_req));

endmodule

bind cfgio_decoder cfgio_decoder_chk #(
  .IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .NLANE(NLANE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_req     (io_req),
  .io_wr      (io_wr),
  .io_addr    (io_addr),
  .io_size    (io_size),
  .io_ack     (io_ack),
  .cfg_req    (cfg_req),
  .cfg_be     (cfg_be),
  .pt_req     (pt_req),
  .cfg_addr_q (cfg_addr_q),
  .seq_idle   (seq_idle)
);

// File: tb/test_cfgio_decoder.sv
`timescale 1ns/1ps
module test_cfgio_decoder;

  localparam int TMO = 64;

  logic        clk;
  logic        rst_n;
  logic        io_req, io_wr;
  logic [15:0] io_addr;
  logic [1:0]  io_size;
  logic [31:0] io_wdata;
  logic        io_ack;
  logic [31:0] io_rdata;
  logic        cfg_req, cfg_wr;
  logic [7:0]  cfg_bus, cfg_devfn;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_ack, cfg_err;
  logic [31:0] cfg_rdata;
  logic        pt_req, pt_wr;
  logic [15:0] pt_addr;
  logic [1:0]  pt_size;
  logic [31:0] pt_wdata;
  logic        pt_ack;
  logic [31:0] pt_rdata;
  logic [7:0]  mech_mode;

  cfgio_decoder #(.TIMEOUT(TMO)) i_cfgio_decoder (
    .clk(clk), .rst_n(rst_n),
    .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr), .io_size(io_size),
    .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata),
    .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn),
    .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_ack(cfg_ack), .cfg_err(cfg_err), .cfg_rdata(cfg_rdata),
    .pt_req(pt_req), .pt_wr(pt_wr), .pt_addr(pt_addr), .pt_size(pt_size),
    .pt_wdata(pt_wdata), .pt_ack(pt_ack), .pt_rdata(pt_rdata),
    .mech_mode(mech_mode)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // back-end model state
  logic [31:0] mem [64];
  int          be_mode = 0;   // 0 normal, 1 abort, 2 silent
  int          be_lat  = 0;
  int          cfg_cnt = 0;
  int          pt_cnt  = 0;
  logic [7:0]  l_bus, l_devfn;
  logic [5:0]  l_reg;
  logic [3:0]  l_be;
  logic [31:0] l_wdata;
  logic        l_wr;
  int          last_lat;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // driver: push expectation, pulse request, wait for completion
  task automatic io_op(input bit wr, input logic [15:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [31:0] exp, input string tag);
    int lat;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    io_req = 1'b1; io_wr = wr; io_addr = a; io_size = sz; io_wdata = wd;
    @(negedge clk);
    io_req = 1'b0;
    lat = 1;
    while (!io_ack && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    if (lat >= 2000) check(1'b0, {tag, " no completion"}, 32'(lat), 32'd0);
    last_lat = lat;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && io_ack) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R13 unexpected io_ack", io_rdata, 32'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(io_rdata === e, t, io_rdata, e);
      end
    end
  end

  // configuration back-end model
  initial begin
    cfg_ack = 1'b0; cfg_err = 1'b0; cfg_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && cfg_req) begin
        cfg_cnt++;
        l_bus = cfg_bus; l_devfn = cfg_devfn; l_reg = cfg_reg;
        l_be = cfg_be; l_wdata = cfg_wdata; l_wr = cfg_wr;
        if (be_mode != 2) begin
          repeat (be_lat) @(negedge clk);
          cfg_ack   = 1'b1;
          cfg_err   = (be_mode == 1);
          cfg_rdata = mem[l_reg];
          if (be_mode == 0 && l_wr) begin
            for (int i = 0; i < 4; i++)
              if (l_be[i]) mem[l_reg][8*i +: 8] = l_wdata[8*i +: 8];
          end
          @(negedge clk);
          cfg_ack = 1'b0;
          cfg_err = 1'b0;
        end
      end
    end
  end

  // pass-through model: answers in the cycle it sees the request
  initial begin
    pt_ack = 1'b0; pt_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && pt_req) begin
        pt_cnt++;
        pt_ack   = 1'b1;
        pt_rdata = 32'hA5A5_0000 | {16'h0, pt_addr};
        @(negedge clk);
        pt_ack = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd0);
    summary();
  end

  initial begin
    int c0, p0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    io_req = 1'b0; io_wr = 1'b0; io_addr = '0; io_size = '0; io_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(io_ack == 1'b0 && cfg_req == 1'b0 && pt_req == 1'b0, "R1 outputs idle",
          {29'd0, io_ack, cfg_req, pt_req}, 32'd0);
    check(mech_mode == 8'h00, "R1 mode byte", {24'd0, mech_mode}, 32'd0);
    io_op(1'b0, 16'h0CF8, 2'd2, 0, 32'h0000_0000, "R1 latch reset value");

    // R2 detection pattern and R13 latency
    io_op(1'b1, 16'h0CF8, 2'd2, 32'h8000_0000, 32'h0, "R13 latch write rdata");
    check(last_lat == 1, "R13 latch ack latency", 32'(last_lat), 32'd1);
    io_op(1'b0, 16'h0CF8, 2'd2, 0, 32'h8000_0000, "R2 enable readback");
    io_op(1'b1, 16'h0CF8, 2'd2, 32'h1234_567F, 32'h0, "R2 write");
    io_op(1'b0, 16'h0CF8, 2'd2, 0, 32'h1234_567C, "R2 low bits zero");
    io_op(1'b1, 16'h0CF8, 2'd2, 32'h8000_0000, 32'h0, "R2 restore");
    io_op(1'b0, 16'h0CF8, 2'd2, 0, 32'h8000_0000, "R2 restored value");

    // R3 mode byte
    io_op(1'b1, 16'h0CFB, 2'd0, 32'h0000_0001, 32'h0, "R3 mode write");
    check(mech_mode == 8'h01, "R3 mode output", {24'd0, mech_mode}, 32'h1);
    io_op(1'b0, 16'h0CF8, 2'd2, 0, 32'h8000_0000, "R3 latch unchanged");
    io_op(1'b0, 16'h0CFB, 2'd0, 0, 32'h0000_0001, "R3 mode readback");

    // R4 narrow accesses near the latch
    p0 = pt_cnt;
    io_op(1'b1, 16'h0CF8, 2'd0, 32'h0000_0055, 32'h0, "R4 byte write passes");
    io_op(1'b1, 16'h0CFA, 2'd1, 32'h0000_BEEF, 32'h0, "R4 word write passes");
    io_op(1'b0, 16'h0CF8, 2'd1, 0, 32'h0000_0CF8, "R4 word read passes");
    check(pt_cnt == p0 + 3, "R4 pass-through count", 32'(pt_cnt - p0), 32'd3);
    io_op(1'b0, 16'h0CF8, 2'd2, 0, 32'h8000_0000, "R4 latch unchanged");

    // R5 R6 R7 R8 config cycles
    io_op(1'b1, 16'h0CF8, 2'd2, 32'h8005_2A10, 32'h0, "R5 set target");
    io_op(1'b1, 16'h0CFC, 2'd2, 32'hDEAD_BEEF, 32'h0, "R5 dword write");
    check(l_bus == 8'h05 && l_devfn == 8'h2A && l_reg == 6'd4 && l_wr,
          "R5 request fields", {8'h0, l_bus, l_devfn, 2'b0, l_reg}, 32'h0005_2A04);
    check(l_be == 4'hF, "R6 dword enables", {28'd0, l_be}, 32'hF);
    check(l_wdata == 32'hDEAD_BEEF, "R7 dword lanes", l_wdata, 32'hDEAD_BEEF);
    io_op(1'b0, 16'h0CFC, 2'd2, 0, 32'hDEAD_BEEF, "R8 dword read");
    io_op(1'b1, 16'h0CFD, 2'd0, 32'h0000_0077, 32'h0, "R7 byte write");
    check(l_be == 4'b0010, "R6 byte lane 1", {28'd0, l_be}, 32'h2);
    check(l_wdata == 32'h0000_7700, "R7 byte steering", l_wdata, 32'h0000_7700);
    io_op(1'b0, 16'h0CFC, 2'd2, 0, 32'hDEAD_77EF, "R7 merged dword");
    io_op(1'b0, 16'h0CFE, 2'd0, 0, 32'h0000_00AD, "R8 byte lane 2");
    check(l_be == 4'b0100, "R6 byte lane 2", {28'd0, l_be}, 32'h4);
    io_op(1'b0, 16'h0CFF, 2'd0, 0, 32'h0000_00DE, "R8 byte lane 3");
    check(l_be == 4'b1000, "R6 byte lane 3", {28'd0, l_be}, 32'h8);
    io_op(1'b0, 16'h0CFE, 2'd1, 0, 32'h0000_DEAD, "R8 upper word");
    io_op(1'b1, 16'h0CFE, 2'd1, 32'h0000_1122, 32'h0, "R7 upper word write");
    check(l_be == 4'b1100, "R6 upper word", {28'd0, l_be}, 32'hC);
    check(l_wdata == 32'h1122_0000, "R7 word steering", l_wdata, 32'h1122_0000);
    be_lat = 3;
    io_op(1'b0, 16'h0CFC, 2'd1, 0, 32'h0000_77EF, "R8 lower word slow back end");
    check(l_be == 4'b0011, "R6 lower word", {28'd0, l_be}, 32'h3);
    be_lat = 0;
    io_op(1'b1, 16'h0CF8, 2'd2, 32'h8000_0014, 32'h0, "R5 second target");
    io_op(1'b1, 16'h0CFC, 2'd2, 32'h0BAD_F00D, 32'h0, "R5 write reg 5");
    check(l_reg == 6'd5 && l_bus == 8'h00, "R5 reg index", {24'd0, 2'b0, l_reg}, 32'd5);
    io_op(1'b0, 16'h0CFC, 2'd2, 0, 32'h0BAD_F00D, "R8 read reg 5");

    // R9 enable clear
    io_op(1'b1, 16'h0CF8, 2'd2, 32'h0005_2A10, 32'h0, "R9 disable");
    c0 = cfg_cnt;
    io_op(1'b0, 16'h0CFC, 2'd2, 0, 32'hA5A5_0CFC, "R9 read passes");
    io_op(1'b1, 16'h0CFD, 2'd0, 32'h0000_0099, 32'h0, "R9 write passes");
    check(cfg_cnt == c0, "R9 no config request", 32'(cfg_cnt - c0), 32'd0);
    io_op(1'b1, 16'h0CF8, 2'd2, 32'h8005_2A10, 32'h0, "R9 enable");
    io_op(1'b0, 16'h0CFC, 2'd2, 0, 32'h1122_77EF, "R9 config data untouched");

    // R12 misaligned window accesses
    c0 = cfg_cnt;
    io_op(1'b0, 16'h0CFD, 2'd1, 0, 32'h0000_0CFD, "R12 odd word passes");
    io_op(1'b0, 16'h0CFE, 2'd2, 0, 32'hA5A5_0CFE, "R12 offset dword passes");
    check(cfg_cnt == c0, "R12 no config request", 32'(cfg_cnt - c0), 32'd0);

    // R10 abort
    be_mode = 1;
    io_op(1'b0, 16'h0CFE, 2'd1, 0, 32'h0000_FFFF, "R10 word abort");
    io_op(1'b0, 16'h0CFD, 2'd0, 0, 32'h0000_00FF, "R10 byte abort");
    io_op(1'b0, 16'h0CFC, 2'd2, 0, 32'hFFFF_FFFF, "R10 dword abort");
    io_op(1'b1, 16'h0CFC, 2'd2, 32'h0, 32'h0, "R10 write abort completes");
    be_mode = 0;
    io_op(1'b0, 16'h0CFC, 2'd2, 0, 32'h1122_77EF, "R10 aborted write dropped");

    // R11 no response
    be_mode = 2;
    io_op(1'b0, 16'h0CFC, 2'd2, 0, 32'hFFFF_FFFF, "R11 dword timeout");
    check(last_lat >= TMO, "R11 timeout length", 32'(last_lat), 32'(TMO));
    io_op(1'b0, 16'h0CFF, 2'd0, 0, 32'h0000_00FF, "R11 byte timeout");
    io_op(1'b1, 16'h0CFC, 2'd2, 32'h0, 32'h0, "R11 write timeout completes");
    be_mode = 0;
    io_op(1'b0, 16'h0CFC, 2'd2, 0, 32'h1122_77EF, "R11 timed-out write dropped");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R13 every request completed", 32'(exp_q.size()), 32'd0);
    summary();
  end

endmodule